// File: doc/BRIEF.md
# Timer event flag and interrupt unit

This block is a 16-bit free-running up-counter with three event sources: a capture strobe, a match against a compare register, and a wrap of the counter past its top value. Each source owns one sticky bit in a flag register. A flag stays set until software writes a one to that bit, or until the processor takes the matching interrupt and pulses that source's acknowledge input.

A per-source enable bit in a mask register and one global enable gate each flag onto its own interrupt request line. Software reaches the registers over a plain register bus: address, write strobe, write data, and combinational read data. Bytes are addressed with a stride of two. The capture register can be loaded both from the bus and by hardware. The counter can also be loaded from the bus.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset the counter, compare, capture, mask and flag registers all read 0 and every interrupt request is low.
- R2: Bits 15..3 of the flag register (offset 0x18) and of the mask register (offset 0x1A) always read 0, and writes to those bits have no effect.
- R3: When `cap_evt` is high at a rising edge, that edge copies the counter value of the same cycle into the capture register (offset 0x12) and sets flag bit 2. A bus write to the capture register in the same cycle loses to the hardware load.
- R4: A match cycle is one in which `cnt_en` is high, no counter write is made, and the counter equals the compare register (offset 0x10). The match sets flag bit 1 at the second rising edge after the match cycle begins, one edge later than the counter advances. A counter that is held at the compare value produces no match.
- R5: Flag bit 0 is set at the edge where the counter advances from 0xFFFF to 0x0000. It is set exactly once for each such pass.
- R6: Writing a word to offset 0x18 clears every flag bit whose written bit is 1. Flag bits written with 0 keep their value.
- R7: A high `vec_ack[i]` at an edge clears flag bit i, where bit 2 is capture, bit 1 is compare and bit 0 is overflow.
- R8: `irq[i]` is high exactly when flag bit i, mask bit i (offset 0x1A, same bit order) and `gie` are all high.
- R9: A hardware set of a flag at the same edge as a clear of that flag, by write-one or by acknowledge, leaves the flag set.
- R10: The compare, capture and counter (offset 0x14) registers read back the 16-bit value last written to them. A counter write takes priority over counting in that cycle.
- R11: With `cnt_en` high and no counter write, the counter increases by one per clock and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| cap_evt | input | 1 | Capture event strobe |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| vec_ack | input | 3 | Per-source vector-taken acknowledge |
| irq | output | 3 | Per-source interrupt request |

## Verification
The hardest case to reach from the ports is a flag hit by a hardware set and a clear at the same edge. For the compare flag this is harder still, because its set comes one cycle after the match. The stimulus loads the counter a few counts below a chosen compare value, enables counting, and then issues the clear on each of the following cycles. This lands one clear exactly on the delayed set.

Overflow is reached without tens of thousands of cycles by loading the counter just below 0xFFFF. The request gating is swept over every combination of flag pattern, mask value and global enable.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_OVF = 0;
  localparam int SRC_CMP = 1;
  localparam int SRC_CAP = 2;

  localparam int OFS_CMP = 'h10;
  localparam int OFS_CAP = 'h12;
  localparam int OFS_CNT = 'h14;
  localparam int OFS_FLG = 'h18;
  localparam int OFS_MSK = 'h1A;
endpackage

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             top_o
);
  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  // counting is blocked in a cycle that loads the counter
  assign tick_o = en_i & ~ld_i;
  assign top_o  = tick_o & (cnt_q == TOP_VAL);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (en_i)   cnt_q <= step(cnt_q);
  end

  // R11: advancing from the top value lands on zero
  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    top_o |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // a set in the same cycle as a clear keeps the flag
  function automatic logic upd(input logic f, input logic s, input logic c);
    return s | (f & ~c);
  endfunction

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= upd(flag_q[i], set_i[i], clr_i[i]);
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_q));
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq #(
  parameter int N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] mask_i,
  input  logic         gie_i,
  output logic [N-1:0] irq_o
);
  function automatic logic [N-1:0] gate(input logic [N-1:0] f,
                                        input logic [N-1:0] m,
                                        input logic g);
    return f & m & {N{g}};
  endfunction

  assign irq_o = gate(flag_i, mask_i, gie_i);
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cap_evt,
  input  logic              gie,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NSRC-1:0]   vec_ack,
  output logic [NSRC-1:0]   irq
);
  localparam int PAD_W = CNT_W - NSRC;

  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAP);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(OFS_FLG);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MSK);

  // write decode
  logic wr_cmp, wr_cap, wr_cnt, wr_flg, wr_msk;
  assign wr_cmp = bus_wr & (bus_addr == A_CMP);
  assign wr_cap = bus_wr & (bus_addr == A_CAP);
  assign wr_cnt = bus_wr & (bus_addr == A_CNT);
  assign wr_flg = bus_wr & (bus_addr == A_FLG);
  assign wr_msk = bus_wr & (bus_addr == A_MSK);

  // counter
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_tick;
  logic             ovf_evt;

  tmr_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (cnt_en),
    .ld_i     (wr_cnt),
    .ld_val_i (bus_wdata),
    .cnt_o    (cnt_q),
    .tick_o   (cnt_tick),
    .top_o    (ovf_evt)
  );

  // compare register and delayed match
  logic [CNT_W-1:0] cmp_q;
  logic             match_evt;
  logic             cmp_hit_q;

  assign match_evt = cnt_tick & (cnt_q == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q     <= '0;
      cmp_hit_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= bus_wdata;
      cmp_hit_q <= match_evt;
    end
  end

  // capture register, hardware load first
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
    else if (wr_cap)  cap_q <= bus_wdata;
  end

  // mask register
  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_msk) mask_q <= bus_wdata[NSRC-1:0];
  end

  // flag set and clear vectors
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_q;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_CAP] = cap_evt;
    set_vec[SRC_CMP] = cmp_hit_q;
    set_vec[SRC_OVF] = ovf_evt;
  end

  assign clr_vec = (wr_flg ? bus_wdata[NSRC-1:0] : '0) | vec_ack;

  tmr_evt_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flag_q)
  );

  tmr_evt_irq #(.N(NSRC)) u_irq (
    .flag_i (flag_q),
    .mask_i (mask_q),
    .gie_i  (gie),
    .irq_o  (irq)
  );

  // read mux
  always_comb begin
    case (bus_addr)
      A_CMP:   bus_rdata = cmp_q;
      A_CAP:   bus_rdata = cap_q;
      A_CNT:   bus_rdata = cnt_q;
      A_FLG:   bus_rdata = {{PAD_W{1'b0}}, flag_q};
      A_MSK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
      default: bus_rdata = '0;
    endcase
  end

  p_cap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q)));

  p_cmp_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> ##1 flag_q[SRC_CMP]);

  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q[SRC_OVF]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (gie && (|(flag_q & mask_q))));

  p_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == A_FLG) || (bus_addr == A_MSK)) |-> (bus_rdata[CNT_W-1:NSRC] == '0));
endmodule

// File: tb/tb_tmr_evt_unit.sv
`timescale 1ns/100ps
module tb_tmr_evt_unit;
  localparam logic [5:0] A_CMP = 6'h10;
  localparam logic [5:0] A_CAP = 6'h12;
  localparam logic [5:0] A_CNT = 6'h14;
  localparam logic [5:0] A_FLG = 6'h18;
  localparam logic [5:0] A_MSK = 6'h1A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cap_evt = 1'b0;
  logic        gie = 1'b0;
  logic [5:0]  bus_addr = A_FLG;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  vec_ack = '0;
  logic [2:0]  irq;

  always #5 clk = ~clk;

  tmr_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_evt(cap_evt), .gie(gie),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vec_ack(vec_ack), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference state, restated from the requirements
  logic [15:0] m_cnt = '0, m_cmp = '0, m_cap = '0;
  logic [2:0]  m_flag = '0, m_mask = '0;
  logic        m_hit = 1'b0;
  logic        g = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // one clock with the given inputs; afterwards flags and irq are compared
  task automatic tick(input logic w, input logic [5:0] a, input logic [15:0] d,
                      input logic e, input logic c, input logic [2:0] k,
                      input string tag);
    logic       wc, adv;
    logic [2:0] sv, cv;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    cnt_en = e; cap_evt = c; vec_ack = k; gie = g;
    @(posedge clk);
    wc = w && (a == A_CNT);
    adv = e && !wc;
    sv = {c, m_hit, adv && (m_cnt == 16'hFFFF)};
    cv = ((w && (a == A_FLG)) ? d[2:0] : 3'b000) | k;
    m_flag = sv | (m_flag & ~cv);
    m_hit = adv && (m_cnt == m_cmp);
    if (c) m_cap = m_cnt;
    else if (w && (a == A_CAP)) m_cap = d;
    if (w && (a == A_CMP)) m_cmp = d;
    if (w && (a == A_MSK)) m_mask = d[2:0];
    if (wc) m_cnt = d;
    else if (adv) m_cnt = m_cnt + 16'd1;
    #1;
    bus_wr = 1'b0; cap_evt = 1'b0; vec_ack = '0; cnt_en = 1'b0; bus_addr = A_FLG;
    #1;
    chk(tag, bus_rdata, {13'b0, m_flag});
    chk(tag, {13'b0, irq}, {13'b0, m_flag & m_mask & {3{g}}});
  endtask

  task automatic idle(input logic e, input string tag);
    tick(1'b0, A_FLG, 16'h0, e, 1'b0, 3'b000, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
    tick(1'b1, a, d, 1'b0, 1'b0, 3'b000, tag);
  endtask

  task automatic set_all();
    wr(A_CMP, 16'hFFFF, "R8");
    wr(A_CNT, 16'hFFFF, "R8");
    tick(1'b0, A_FLG, 16'h0, 1'b1, 1'b1, 3'b000, "R8");
    idle(1'b0, "R4");
    idle(1'b0, "R8");
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    rd(A_FLG, 16'h0, "R1");
    rd(A_MSK, 16'h0, "R1");
    rd(A_CNT, 16'h0, "R1");
    idle(1'b0, "R1");
    rd(A_CMP, 16'h0, "R1");
    rd(A_CAP, 16'h0, "R1");
    chk("R1", {13'b0, irq}, 16'h0);

    // R2: reserved bits
    wr(A_FLG, 16'hFFF8, "R2");
    rd(A_FLG, 16'h0000, "R2");
    wr(A_MSK, 16'hFFFF, "R2");
    rd(A_MSK, 16'h0007, "R2");
    wr(A_MSK, 16'h0000, "R2");

    // R10: register read-back
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = (16'h1357 * 16'(i)) ^ 16'hA5C3;
      wr(A_CMP, v, "R10");
      rd(A_CMP, v, "R10");
      wr(A_CAP, ~v, "R10");
      rd(A_CAP, ~v, "R10");
      wr(A_CNT, v ^ 16'h0F0F, "R10");
      rd(A_CNT, v ^ 16'h0F0F, "R10");
    end
    wr(A_CMP, 16'h7000, "R10");

    // R3: capture of held counter values
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'h1111 * 16'(i) + 16'd3;
      wr(A_CNT, v, "R3");
      tick(1'b0, A_FLG, 16'h0, 1'b0, 1'b1, 3'b000, "R3");
      rd(A_CAP, v, "R3");
      wr(A_FLG, 16'h0004, "R6");
    end
    // R3/R11: capture while counting
    wr(A_CNT, 16'd100, "R11");
    repeat (3) idle(1'b1, "R11");
    tick(1'b0, A_FLG, 16'h0, 1'b1, 1'b1, 3'b000, "R3");
    rd(A_CAP, 16'd103, "R3");
    rd(A_CNT, 16'd104, "R11");
    // R3: hardware load beats a bus write
    wr(A_CNT, 16'd500, "R3");
    tick(1'b1, A_CAP, 16'hBEEF, 1'b0, 1'b1, 3'b000, "R3");
    rd(A_CAP, 16'd500, "R3");
    // R9: set and write-one clear at the same edge
    tick(1'b1, A_FLG, 16'h0004, 1'b0, 1'b1, 3'b000, "R9");
    rd(A_FLG, 16'h0004, "R9");
    wr(A_FLG, 16'h0007, "R6");

    // R4: compare timing for several compare values
    for (int i = 0; i < 4; i++) begin
      logic [15:0] c;
      c = 16'h0003 + 16'h3FF7 * 16'(i);
      wr(A_CMP, c, "R4");
      wr(A_CNT, c - 16'd3, "R4");
      repeat (3) idle(1'b1, "R4");
      idle(1'b1, "R4");
      rd(A_FLG, 16'h0000, "R4");
      idle(1'b1, "R4");
      rd(A_FLG, 16'h0002, "R4");
      wr(A_FLG, 16'h0007, "R6");
      // counter held on the compare value: no match
      wr(A_CNT, c, "R4");
      repeat (4) idle(1'b0, "R4");
      rd(A_FLG, 16'h0000, "R4");
    end
    // R9: compare set meets a clear, on each offset around the match
    for (int off = 0; off < 5; off++) begin
      wr(A_CMP, 16'h0200, "R9");
      wr(A_CNT, 16'h01FE, "R9");
      for (int j = 0; j < 6; j++)
        tick(j == off, A_FLG, 16'h0002, 1'b1, 1'b0, 3'b000, "R9");
      wr(A_FLG, 16'h0007, "R6");
    end

    // R5: overflow once per pass
    wr(A_CMP, 16'h1000, "R5");
    wr(A_CNT, 16'hFFFD, "R5");
    repeat (6) idle(1'b1, "R5");
    rd(A_CNT, m_cnt, "R11");
    rd(A_FLG, 16'h0001, "R5");
    wr(A_FLG, 16'h0001, "R6");
    repeat (20) idle(1'b1, "R5");
    rd(A_FLG, 16'h0000, "R5");
    // R9: overflow meets acknowledge
    wr(A_CNT, 16'hFFFF, "R9");
    tick(1'b0, A_FLG, 16'h0, 1'b1, 1'b0, 3'b001, "R9");
    rd(A_FLG, 16'h0001, "R9");

    // R6/R7: write-zero keeps, acknowledge clears one source
    set_all();
    wr(A_FLG, 16'h0000, "R6");
    rd(A_FLG, 16'h0007, "R6");
    tick(1'b0, A_FLG, 16'h0, 1'b0, 1'b0, 3'b010, "R7");
    rd(A_FLG, 16'h0005, "R7");
    tick(1'b0, A_FLG, 16'h0, 1'b0, 1'b0, 3'b001, "R7");
    rd(A_FLG, 16'h0004, "R7");
    tick(1'b0, A_FLG, 16'h0, 1'b0, 1'b1, 3'b100, "R9");
    rd(A_FLG, 16'h0004, "R9");
    tick(1'b0, A_FLG, 16'h0, 1'b0, 1'b0, 3'b100, "R7");
    rd(A_FLG, 16'h0000, "R7");

    // R8: every flag pattern, mask and global enable
    for (int f = 0; f < 8; f++) begin
      g = 1'b0;
      set_all();
      wr(A_FLG, 16'(~f & 7), "R6");
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 2; e++) begin
          g = e[0];
          wr(A_MSK, 16'(m), "R8");
          chk("R8", {13'b0, irq}, 16'((f & m) * e));
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule